// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer state for one channel of a four-channel DMA controller. Software-side logic loads a 16-bit start address, a 16-bit transfer count, an 8-bit page byte and a mode byte through separate write strobes. After that, each pulse on the transfer strobe moves the address by one, either up or down, and takes one off the count. The block also keeps a copy of the programmed address and count. When auto-initialize is on, it returns to that copy at the end of a run.

The memory address it drives is 24 bits wide: the page byte on top of the 16-bit stepping address. Once the count runs out, a one-cycle terminal-count pulse fires and a sticky flag is set; a clear input drops the flag again. Transfer type, mode and direction are decoded from the stored mode byte and driven out for the surrounding controller to use. The block moves no data and does no arbitration.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the memory address, current count, terminal-count pulse, sticky flag and all decoded mode outputs are zero.
- R2: A pulse on `addr_wr` loads `addr_wdata` into both the current and the base address. A pulse on `cnt_wr` loads `cnt_wdata` into both the current and the base count.
- R3: `mem_addr[23:16]` is the page byte loaded by `page_wr`, and `mem_addr[15:0]` is the current address.
- R4: A mode byte written by `mode_wr` is decoded as follows:
  - bits 3:2 are the transfer type (0 verify, 1 write to memory, 2 read from memory, 3 invalid);
  - bit 4 is auto-initialize;
  - bit 5 selects decrementing addresses;
  - bits 7:6 are the mode (0 demand, 1 single, 2 block, 3 cascade);
  - bits 1:0 have no effect.
- R5: An accepted transfer with bit 5 clear adds one to the current address, and one with bit 5 set subtracts one. Either way the step wraps within 16 bits.
- R6: An accepted transfer never changes the page byte. A wrap from 0xFFFF to 0x0000, or the other way, leaves `mem_addr[23:16]` unchanged.
- R7: Each accepted transfer takes one off the current count. The transfer taken when the count is 0x0000 gives a one-cycle `tc` pulse in the following cycle, so a loaded count N gives exactly one pulse after N+1 transfers.
- R8: When auto-initialize is set, the transfer that produces terminal count reloads the current address and count from the base copies instead of stepping.
- R9: `tc_flag` sets together with `tc` and stays set until `tc_clr` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R10: A transfer strobe in cascade mode, or with transfer type 3, changes neither address nor count and gives no `tc`. A transfer strobe in the same cycle as any register write is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Load current and base address |
| addr_wdata | input | 16 | Address value |
| cnt_wr | input | 1 | Load current and base count |
| cnt_wdata | input | 16 | Count value |
| page_wr | input | 1 | Load page byte |
| page_wdata | input | 8 | Page value |
| mode_wr | input | 1 | Load mode byte |
| mode_wdata | input | 8 | Mode byte |
| xfer | input | 1 | One transfer taken this cycle |
| tc_clr | input | 1 | Clear sticky terminal-count flag |
| mem_addr | output | 24 | Page byte over current address |
| cur_cnt | output | 16 | Current count |
| tc | output | 1 | Terminal-count pulse |
| tc_flag | output | 1 | Sticky terminal-count flag |
| addr_down | output | 1 | Address decrement selected |
| auto_init | output | 1 | Auto-initialize selected |
| xfer_type | output | 2 | Decoded transfer type |
| xfer_mode | output | 2 | Decoded mode |

## Verification
The base registers have no output, so the hardest state to observe is the base copy. It only shows up when an auto-initialize run reaches terminal count. The bench programs a run with auto-initialize, steps it past the count's rollover, and checks that the address and count return to the loaded values and not to stepped ones. The page-carry case also needs setup: the address is started one or two steps below 0xFFFF (or above 0x0000 when counting down), so that the 16-bit wrap falls inside a short run.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          page_wr,
  input  logic [PW-1:0] page_wdata,
  input  logic          mode_wr,
  input  logic [7:0]    mode_wdata,
  input  logic          xfer,
  input  logic          tc_clr,
  output logic [PW+AW-1:0] mem_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          tc,
  output logic          tc_flag,
  output logic          addr_down,
  output logic          auto_init,
  output logic [1:0]    xfer_type,
  output logic [1:0]    xfer_mode
);
  logic [AW-1:0] cur_addr, base_addr;
  logic [CW-1:0] base_cnt;
  logic [PW-1:0] page;
  logic [5:0]    mode_q;

  assign xfer_type = mode_q[1:0];
  assign auto_init = mode_q[2];
  assign addr_down = mode_q[3];
  assign xfer_mode = mode_q[5:4];
  assign mem_addr  = {page, cur_addr};

  wire any_wr  = addr_wr | cnt_wr | page_wr | mode_wr;
  wire take    = xfer & ~any_wr & (xfer_mode != 2'd3) & (xfer_type != 2'd3);
  wire at_end  = take & (cur_cnt == '0);
  wire reload  = at_end & auto_init;
  wire [AW-1:0] next_addr = addr_down ? cur_addr - 1'b1 : cur_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      base_addr <= '0;
      cur_cnt   <= '0;
      base_cnt  <= '0;
      page      <= '0;
      mode_q    <= '0;
      tc        <= 1'b0;
      tc_flag   <= 1'b0;
    end else begin
      tc <= at_end;
      if (at_end)      tc_flag <= 1'b1;
      else if (tc_clr) tc_flag <= 1'b0;
      if (page_wr) page   <= page_wdata;
      if (mode_wr) mode_q <= mode_wdata[7:2];
      if (addr_wr) begin
        cur_addr  <= addr_wdata;
        base_addr <= addr_wdata;
      end else if (reload) begin
        cur_addr <= base_addr;
      end else if (take) begin
        cur_addr <= next_addr;
      end
      if (cnt_wr) begin
        cur_cnt  <= cnt_wdata;
        base_cnt <= cnt_wdata;
      end else if (reload) begin
        cur_cnt <= base_cnt;
      end else if (take) begin
        cur_cnt <= cur_cnt - 1'b1;
      end
    end
  end
endmodule

module dma_chan_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_wr,
  input logic          cnt_wr,
  input logic          page_wr,
  input logic          mode_wr,
  input logic          xfer,
  input logic          tc_clr,
  input logic [PW+AW-1:0] mem_addr,
  input logic [CW-1:0] cur_cnt,
  input logic          tc,
  input logic          tc_flag,
  input logic          addr_down,
  input logic          auto_init,
  input logic [1:0]    xfer_type,
  input logic [1:0]    xfer_mode
);
  wire quiet   = ~(addr_wr | cnt_wr | page_wr | mode_wr);
  wire ok      = xfer & quiet & (xfer_mode != 2'd3) & (xfer_type != 2'd3);
  wire blocked = xfer & quiet & ((xfer_mode == 2'd3) | (xfer_type == 2'd3));
  wire stepok  = ok & ~((cur_cnt == '0) & auto_init);

  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepok & ~addr_down |=> mem_addr[AW-1:0] == $past(mem_addr[AW-1:0]) + 1'b1);
  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepok & addr_down |=> mem_addr[AW-1:0] == $past(mem_addr[AW-1:0]) - 1'b1);
  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> $stable(mem_addr[PW+AW-1:AW]));
  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepok |=> cur_cnt == $past(cur_cnt) - 1'b1);
  // R7
  tc_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok & (cur_cnt == '0) |=> tc);
  // R9
  flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> tc_flag);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_clr & ~tc & ~(ok & (cur_cnt == '0)) |=> ~tc_flag);
  // R10
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(cur_cnt) && $stable(mem_addr) && !tc);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .CW(CW), .PW(PW)) u_chk (.*);

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic addr_wr = 0, cnt_wr = 0, page_wr = 0, mode_wr = 0, xfer = 0, tc_clr = 0;
  logic [15:0] addr_wdata = 0, cnt_wdata = 0;
  logic [7:0] page_wdata = 0, mode_wdata = 0;
  logic [23:0] mem_addr;
  logic [15:0] cur_cnt;
  logic tc, tc_flag, addr_down, auto_init;
  logic [1:0] xfer_type, xfer_mode;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_chan_engine u_dma_chan_engine (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_addr(logic [15:0] v);
    @(negedge clk); addr_wr = 1; addr_wdata = v; @(negedge clk); addr_wr = 0;
  endtask
  task automatic wr_cnt(logic [15:0] v);
    @(negedge clk); cnt_wr = 1; cnt_wdata = v; @(negedge clk); cnt_wr = 0;
  endtask
  task automatic wr_page(logic [7:0] v);
    @(negedge clk); page_wr = 1; page_wdata = v; @(negedge clk); page_wr = 0;
  endtask
  task automatic wr_mode(logic [7:0] v);
    @(negedge clk); mode_wr = 1; mode_wdata = v; @(negedge clk); mode_wr = 0;
  endtask
  task automatic pulse_xfer();
    @(negedge clk); xfer = 1; @(negedge clk); xfer = 0;
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] ea, ec;
    int tcs;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 addr", mem_addr, 0);
    check("R1 cnt", cur_cnt, 0);
    check("R1 tc", {tc, tc_flag}, 0);
    check("R1 mode", {addr_down, auto_init, xfer_type, xfer_mode}, 0);
    rst_n = 1;

    // R4 decode of every mode byte; low two bits ignored
    for (int m = 0; m < 256; m++) begin
      wr_mode(m[7:0]);
      check("R4 decode", {addr_down, auto_init, xfer_type, xfer_mode},
            {m[5], m[4], m[3:2], m[7:6]});
    end

    // R2 R3 R5 R6 R7 up-count across a wrap
    wr_mode(8'h47); wr_page(8'hA5); wr_addr(16'hFFFE); wr_cnt(16'd3);
    check("R2 load addr", mem_addr, 24'hA5FFFE);
    check("R2 load cnt", cur_cnt, 3);
    check("R3 page", mem_addr[23:16], 8'hA5);
    ea = 16'hFFFE; ec = 3;
    for (int i = 0; i < 4; i++) begin
      pulse_xfer();
      ea = ea + 1; ec = ec - 1;
      check("R5 up step", mem_addr[15:0], ea);
      check("R6 page hold", mem_addr[23:16], 8'hA5);
      check("R7 count", cur_cnt, ec);
      check("R7 tc", tc, i == 3);
    end
    @(negedge clk);
    check("R7 tc one cycle", tc, 0);
    check("R9 sticky", tc_flag, 1);
    @(negedge clk); tc_clr = 1; @(negedge clk); tc_clr = 0;
    check("R9 clear", tc_flag, 0);

    // R8 auto-init, decrement, across wrap
    wr_mode(8'hB8); wr_page(8'h3C); wr_addr(16'h0001); wr_cnt(16'd2);
    ea = 16'h0001; ec = 2;
    for (int i = 0; i < 3; i++) begin
      pulse_xfer();
      if (i == 2) begin ea = 16'h0001; ec = 2; end
      else begin ea = ea - 1; ec = ec - 1; end
      check("R5 down step", mem_addr[15:0], ea);
      check("R6 page hold down", mem_addr[23:16], 8'h3C);
      check("R8 count", cur_cnt, ec);
      check("R8 tc", tc, i == 2);
    end

    // R9 set wins over clear
    wr_cnt(16'd0);
    @(negedge clk); xfer = 1; tc_clr = 1; @(negedge clk); xfer = 0; tc_clr = 0;
    check("R9 set wins", {tc, tc_flag}, 2'b11);

    // R10 blocked strobes
    wr_mode(8'hC4); wr_addr(16'h1234); wr_cnt(16'd0);
    pulse_xfer();
    check("R10 cascade addr", mem_addr[15:0], 16'h1234);
    check("R10 cascade cnt/tc", {cur_cnt, tc}, {16'd0, 1'b0});
    wr_mode(8'h4C);
    pulse_xfer();
    check("R10 invalid addr", mem_addr[15:0], 16'h1234);
    check("R10 invalid cnt/tc", {cur_cnt, tc}, {16'd0, 1'b0});
    wr_mode(8'h44);
    @(negedge clk); xfer = 1; page_wr = 1; page_wdata = 8'h77;
    @(negedge clk); xfer = 0; page_wr = 0;
    check("R10 write beats xfer", mem_addr, 24'h771234);
    check("R10 write beats xfer cnt", {cur_cnt, tc}, {16'd0, 1'b0});

    // R7 sweep: count N gives one tc after N+1 transfers, both directions
    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n < 6; n++) begin
        wr_mode(d ? 8'h24 : 8'h04); wr_addr(16'h8000); wr_cnt(n[15:0]);
        tcs = 0;
        for (int k = 0; k <= n; k++) begin
          pulse_xfer();
          if (tc) tcs++;
          if (k < n) check("R7 sweep early tc", tc, 0);
        end
        check("R7 sweep tc count", tcs, 1);
        check("R5 sweep addr", mem_addr[15:0],
              d ? 16'h8000 - 16'(n + 1) : 16'h8000 + 16'(n + 1));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule